// File: doc/BRIEF.md
# Ternary Rule Update Engine for RAM-Based Match Tables

This block holds the match tables of a RAM-based ternary matcher and rewrites them one rule at a time. The tables are arranged as rows of sub-word RAMs. A search key is split into equal sub-words, and each sub-word addresses its own RAM. Every RAM word carries one bit per rule slot of the row. A key therefore matches a slot when that slot's bit is set in all of the row's RAMs at the addresses the sub-words select.

To install a rule, the engine is given a row, a slot, a key value and a care mask. For every address of every RAM in that row, it decides whether the address agrees with the rule's sub-word on the cared bits, and it writes the slot's bit to match. All RAMs of the row are swept in parallel, so an update always costs one setup cycle plus one cycle per RAM address, however many rules the row holds. Only the slot's bit changes: other slots and other rows are untouched.

A delete clears the slot's bit at every address. Searches see backpressure while an update runs, so a half-written rule is never seen. Commands sent while busy are dropped and recorded in a sticky error. Slots beyond the row capacity (RAM word width times the scaling factor) are refused and also recorded.

Top module: `tcam_rule_update`

## Requirements
- R1: After reset, busy, done, err_busy, err_bound and match_valid are 0 and srch_ready is 1.
- R2: An accepted command keeps busy at 1 for exactly 2**SUB_W + 1 cycles, starting the cycle after acceptance. done then pulses for one cycle, with busy at 0.
- R3: cmd_op = 0 writes a rule. Once the update is done, a search of key k in the target row reports the slot's bit set exactly when ((k XOR cmd_value) AND cmd_care) is zero. Sub-word v is bits [v*SUB_W +: SUB_W], and bit i of match_vec is slot i.
- R4: An update leaves the bits of all other slots in the target row unchanged.
- R5: An update leaves every other row unchanged.
- R6: cmd_op = 1 deletes the rule: afterwards no key reports the slot's bit in that row.
- R7: srch_ready is 0 whenever busy is 1, and a search presented while srch_ready is 0 produces no result.
- R8: An accepted search gives match_valid one cycle later. match_vec is then the bit-wise AND of the row's RAM words at the key's sub-word addresses.
- R9: A command presented while busy is ignored: its target is not written, and err_busy becomes 1 and stays 1 until reset.
- R10: A command whose slot is at least ENT_W*SCALE is refused: busy stays 0, no table changes, and err_bound becomes 1 and stays 1 until reset.
- R11: A rule written with an all-zero care mask matches every key of its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Update command strobe |
| cmd_op | input | 1 | 0 = write rule, 1 = delete rule |
| cmd_row | input | ROW_W | Target row |
| cmd_slot | input | SLOT_W | Slot within the row (one bit wider than needed, to allow range checking) |
| cmd_value | input | KEY_W | Rule value |
| cmd_care | input | KEY_W | Care mask, 1 = bit compared |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse when an update finishes |
| err_busy | output | 1 | Sticky: a command arrived while busy |
| err_bound | output | 1 | Sticky: a command named a slot beyond capacity |
| srch_valid | input | 1 | Search request |
| srch_ready | output | 1 | Search can be accepted |
| srch_row | input | ROW_W | Row to search |
| srch_key | input | KEY_W | Search key |
| match_valid | output | 1 | match_vec is valid |
| match_vec | output | CAP | One bit per slot that matched |

## Verification
The bench uses the default parameters: four rows, two RAMs per row with 4-bit sub-words, and four-bit words scaled by two, giving eight slots. A 16-deep RAM makes each sweep 17 busy cycles. That is short enough to clear every slot of every row, and to exercise overwrite, delete and cross-row isolation against a full reference model. The 4-bit slot field with only eight slots makes the refused value 8 reachable. The two sub-words mean that a rule with don't-care bits in one nibble only checks the AND across RAMs.

// File: rtl/tcam_upd_pkg.sv
package tcam_upd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SWEEP = 2'd2
  } upd_state_e;

  typedef enum logic {
    OP_WRITE  = 1'b0,
    OP_DELETE = 1'b1
  } upd_op_e;

endpackage

// File: rtl/tcam_upd_rst_sync.sv
module tcam_upd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/tcam_upd_ctrl.sv
module tcam_upd_ctrl
  import tcam_upd_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int SLOT_W = 4,
  parameter int IDX_W  = 3,
  parameter int SUB_W  = 4,
  parameter int KEY_W  = 8,
  parameter int CAP    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [KEY_W-1:0] cmd_value,
  input  logic [KEY_W-1:0] cmd_care,
  output logic             busy,
  output logic             done,
  output logic             err_busy,
  output logic             err_bound,
  output logic             sweep_we,
  output logic [SUB_W-1:0] sweep_addr,
  output logic [ROW_W-1:0] row_q,
  output logic [IDX_W-1:0] slot_q,
  output logic             op_q,
  output logic [KEY_W-1:0] value_q,
  output logic [KEY_W-1:0] care_q
);
  upd_state_e       state_q, state_d;
  logic [SUB_W-1:0] addr_q, addr_d;
  logic             done_q, done_d;
  logic             eb_q, eb_d, eo_q, eo_d;
  logic             idle, in_range, load;

  assign idle     = (state_q == ST_IDLE);
  assign in_range = (cmd_slot < SLOT_W'(CAP));
  assign load     = idle && cmd_valid && in_range;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    eb_d    = eb_q | (cmd_valid && !idle);
    eo_d    = eo_q | (cmd_valid && idle && !in_range);
    case (state_q)
      ST_IDLE:  if (load) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d = ST_SWEEP;
        addr_d  = '0;
      end
      ST_SWEEP: begin
        addr_d = addr_q + 1'b1;
        if (&addr_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
      eb_q    <= 1'b0;
      eo_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
      eb_q    <= eb_d;
      eo_q    <= eo_d;
    end
  end

  // command holding registers: data only, loaded under an explicit enable
  always_ff @(posedge clk) begin
    if (load) begin
      row_q   <= cmd_row;
      slot_q  <= cmd_slot[IDX_W-1:0];
      op_q    <= cmd_op;
      value_q <= cmd_value;
      care_q  <= cmd_care;
    end
  end

  assign busy       = !idle;
  assign done       = done_q;
  assign err_busy   = eb_q;
  assign err_bound  = eo_q;
  assign sweep_we   = (state_q == ST_SWEEP);
  assign sweep_addr = addr_q;
endmodule

// File: rtl/tcam_upd_lane.sv
module tcam_upd_lane
  import tcam_upd_pkg::*;
#(
  parameter int ROW_W = 2,
  parameter int SUB_W = 4,
  parameter int CAP   = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] wrow,
  input  logic [SUB_W-1:0] waddr,
  input  logic [IDX_W-1:0] wslot,
  input  logic             op,
  input  logic [SUB_W-1:0] val,
  input  logic [SUB_W-1:0] care,
  input  logic             re,
  input  logic [ROW_W-1:0] rrow,
  input  logic [SUB_W-1:0] rkey,
  output logic [CAP-1:0]   rword
);
  localparam int AW    = ROW_W + SUB_W;
  localparam int WORDS = 1 << AW;

  logic [CAP-1:0] mem [WORDS];
  logic [AW-1:0]  widx, ridx;
  logic           wbit;

  assign widx = {wrow, waddr};
  assign ridx = {rrow, rkey};
  // slot bit is set where the swept address agrees with the rule on cared bits
  assign wbit = (op == OP_WRITE) && (((waddr ^ val) & care) == '0);

  always_ff @(posedge clk) begin
    if (we) mem[widx][wslot] <= wbit;
    if (re) rword <= mem[ridx];
  end
endmodule

// File: rtl/tcam_rule_update.sv
module tcam_rule_update #(
  parameter  int ROWS   = 4,
  parameter  int BLOCKS = 2,
  parameter  int SUB_W  = 4,
  parameter  int ENT_W  = 4,
  parameter  int SCALE  = 2,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAP    = ENT_W * SCALE,
  localparam int IDX_W  = (CAP > 1) ? $clog2(CAP) : 1,
  localparam int SLOT_W = IDX_W + 1,
  localparam int KEY_W  = BLOCKS * SUB_W,
  localparam int DEPTH  = 1 << SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [KEY_W-1:0]  cmd_value,
  input  logic [KEY_W-1:0]  cmd_care,
  output logic              busy,
  output logic              done,
  output logic              err_busy,
  output logic              err_bound,
  input  logic              srch_valid,
  output logic              srch_ready,
  input  logic [ROW_W-1:0]  srch_row,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              match_valid,
  output logic [CAP-1:0]    match_vec
);
  logic             rst_sync_n;
  logic             sweep_we;
  logic [SUB_W-1:0] sweep_addr;
  logic [ROW_W-1:0] row_q;
  logic [IDX_W-1:0] slot_q;
  logic             op_q;
  logic [KEY_W-1:0] value_q, care_q;
  logic             rd_en;
  logic             mv_q;
  logic [CAP-1:0]   rword [BLOCKS];
  logic [CAP-1:0]   and_vec;

  tcam_upd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tcam_upd_ctrl #(
    .ROW_W (ROW_W), .SLOT_W (SLOT_W), .IDX_W (IDX_W),
    .SUB_W (SUB_W), .KEY_W (KEY_W), .CAP (CAP)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_row    (cmd_row),
    .cmd_slot   (cmd_slot),
    .cmd_value  (cmd_value),
    .cmd_care   (cmd_care),
    .busy       (busy),
    .done       (done),
    .err_busy   (err_busy),
    .err_bound  (err_bound),
    .sweep_we   (sweep_we),
    .sweep_addr (sweep_addr),
    .row_q      (row_q),
    .slot_q     (slot_q),
    .op_q       (op_q),
    .value_q    (value_q),
    .care_q     (care_q)
  );

  // searches stall for the whole update so no partial rule is observed
  assign srch_ready = !busy;
  assign rd_en      = srch_valid && srch_ready;

  for (genvar v = 0; v < BLOCKS; v++) begin : g_lane
    tcam_upd_lane #(
      .ROW_W (ROW_W), .SUB_W (SUB_W), .CAP (CAP), .IDX_W (IDX_W)
    ) u_lane (
      .clk   (clk),
      .we    (sweep_we),
      .wrow  (row_q),
      .waddr (sweep_addr),
      .wslot (slot_q),
      .op    (op_q),
      .val   (value_q[v*SUB_W +: SUB_W]),
      .care  (care_q[v*SUB_W +: SUB_W]),
      .re    (rd_en),
      .rrow  (srch_row),
      .rkey  (srch_key[v*SUB_W +: SUB_W]),
      .rword (rword[v])
    );
  end

  always_comb begin
    and_vec = '1;
    for (int v = 0; v < BLOCKS; v++) and_vec = and_vec & rword[v];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mv_q <= 1'b0;
    else             mv_q <= rd_en;
  end

  assign match_valid = mv_q;
  assign match_vec   = and_vec;
endmodule

// File: rtl/tcam_rule_update_chk.sv
module tcam_rule_update_chk #(
  parameter int DEPTH  = 16,
  parameter int CAP    = 8,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cmd_valid,
  input logic [SLOT_W-1:0] cmd_slot,
  input logic              err_busy,
  input logic              err_bound,
  input logic              srch_valid,
  input logic              srch_ready,
  input logic              match_valid
);
  localparam int CW = $clog2(DEPTH + 2) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R2: busy window never longer than DEPTH+1 and ends exactly there
  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(DEPTH + 1));
  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == CW'(DEPTH + 1));
  a_r2_done_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R7
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !srch_ready);
  // R8
  a_r8_result: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> $past(srch_valid && srch_ready));
  // R9
  a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> err_busy);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |=> err_busy);
  // R10
  a_r10_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_slot >= SLOT_W'(CAP)) |=> (!busy && err_bound));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_bound |=> err_bound);
endmodule

bind tcam_rule_update tcam_rule_update_chk #(
  .DEPTH (DEPTH), .CAP (CAP), .SLOT_W (SLOT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .busy        (busy),
  .done        (done),
  .cmd_valid   (cmd_valid),
  .cmd_slot    (cmd_slot),
  .err_busy    (err_busy),
  .err_bound   (err_bound),
  .srch_valid  (srch_valid),
  .srch_ready  (srch_ready),
  .match_valid (match_valid)
);

// File: tb/tcam_rule_update_tb.sv
`timescale 1ns/1ps
module tcam_rule_update_tb;
  localparam int ROWS = 4, BLOCKS = 2, SUB_W = 4, ENT_W = 4, SCALE = 2;
  localparam int ROW_W = 2, CAP = ENT_W * SCALE, SLOT_W = 4;
  localparam int KEY_W = BLOCKS * SUB_W, DEPTH = 1 << SUB_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_op = 0;
  logic [ROW_W-1:0] cmd_row = '0;
  logic [SLOT_W-1:0] cmd_slot = '0;
  logic [KEY_W-1:0] cmd_value = '0, cmd_care = '0;
  logic busy, done, err_busy, err_bound;
  logic srch_valid = 0, srch_ready;
  logic [ROW_W-1:0] srch_row = '0;
  logic [KEY_W-1:0] srch_key = '0;
  logic match_valid;
  logic [CAP-1:0] match_vec;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model of installed rules
  bit             m_val  [ROWS][CAP];
  logic [KEY_W-1:0] m_v  [ROWS][CAP];
  logic [KEY_W-1:0] m_c  [ROWS][CAP];
  logic [CAP-1:0] exp_q [$];
  string          tag_q [$];

  always #4 clk = ~clk;

  tcam_rule_update #(.ROWS(ROWS), .BLOCKS(BLOCKS), .SUB_W(SUB_W),
                     .ENT_W(ENT_W), .SCALE(SCALE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_slot(cmd_slot), .cmd_value(cmd_value),
    .cmd_care(cmd_care), .busy(busy), .done(done), .err_busy(err_busy),
    .err_bound(err_bound), .srch_valid(srch_valid), .srch_ready(srch_ready),
    .srch_row(srch_row), .srch_key(srch_key), .match_valid(match_valid),
    .match_vec(match_vec));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [CAP-1:0] expect_vec(input int row, input logic [KEY_W-1:0] key);
    logic [CAP-1:0] r = '0;
    for (int s = 0; s < CAP; s++)
      if (m_val[row][s] && (((key ^ m_v[row][s]) & m_c[row][s]) == '0)) r[s] = 1'b1;
    return r;
  endfunction

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rst_n && match_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7/R8 unexpected result", 32'(match_vec), 32'h0);
      end else begin
        logic [CAP-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(match_vec === e, t, 32'(match_vec), 32'(e));
      end
    end
  end

  task automatic search(input int row, input logic [KEY_W-1:0] key, input string tag);
    @(negedge clk);
    srch_valid = 1; srch_row = ROW_W'(row); srch_key = key;
    if (srch_ready) begin
      exp_q.push_back(expect_vec(row, key));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    srch_valid = 0;
    @(negedge clk);
  endtask

  task automatic issue(input bit op, input int row, input int slot,
                       input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_row = ROW_W'(row);
    cmd_slot = SLOT_W'(slot); cmd_value = v; cmd_care = c;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // R2 timing check, then model update
  task automatic update(input bit op, input int row, input int slot,
                        input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c);
    int n = 0;
    issue(op, row, slot, v, c);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(n == DEPTH + 1, "R2 busy length", 32'(n), 32'(DEPTH + 1));
    check(done === 1'b1, "R2 done at end", 32'(done), 32'h1);
    @(negedge clk);
    check(done === 1'b0, "R2 done single cycle", 32'(done), 32'h0);
    m_val[row][slot] = (op == 1'b0);
    m_v[row][slot] = v;
    m_c[row][slot] = c;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int s = 0; s < CAP; s++) begin m_val[r][s] = 0; m_v[r][s] = '0; m_c[r][s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    check(busy === 0, "R1 busy", 32'(busy), 0);
    check(done === 0, "R1 done", 32'(done), 0);
    check(err_busy === 0, "R1 err_busy", 32'(err_busy), 0);
    check(err_bound === 0, "R1 err_bound", 32'(err_bound), 0);
    check(match_valid === 0, "R1 match_valid", 32'(match_valid), 0);
    check(srch_ready === 1, "R1 srch_ready", 32'(srch_ready), 1);

    // R6: delete every slot of every row to define the tables
    for (int r = 0; r < ROWS; r++)
      for (int s = 0; s < CAP; s++) update(1'b1, r, s, '0, '0);
    search(0, 8'h00, "R6 cleared row0");
    search(3, 8'hFF, "R6 cleared row3");

    // R3 exact rule
    update(1'b0, 1, 2, 8'hA5, 8'hFF);
    search(1, 8'hA5, "R3 exact hit");
    search(1, 8'hA4, "R3 exact miss low nibble");
    search(1, 8'h25, "R3 exact miss high nibble");
    search(0, 8'hA5, "R5 row0 untouched");
    search(2, 8'hA5, "R5 row2 untouched");

    // R8 AND across sub-words: low nibble ignored
    update(1'b0, 1, 5, 8'h30, 8'hF0);
    search(1, 8'h3F, "R8 partial care hit");
    search(1, 8'h37, "R8 partial care hit2");
    search(1, 8'h47, "R8 partial care miss");
    search(1, 8'hA5, "R4 slot2 kept");

    // R11 all don't care
    update(1'b0, 1, 7, 8'h5A, 8'h00);
    search(1, 8'h00, "R11 any key");
    search(1, 8'h30, "R11 with others");
    search(0, 8'h30, "R5 row0 still empty");

    // R3 overwrite clears old matches
    update(1'b0, 1, 2, 8'h11, 8'hFF);
    search(1, 8'hA5, "R3 old key gone");
    search(1, 8'h11, "R3 new key");

    // R6 delete
    update(1'b1, 1, 5, '0, '0);
    search(1, 8'h3F, "R6 deleted slot5");
    search(1, 8'h11, "R4 after delete");

    // R7 / R9: activity during an update
    issue(1'b0, 2, 0, 8'hC3, 8'hFF);
    check(busy === 1, "R2 busy after accept", 32'(busy), 1);
    check(srch_ready === 0, "R7 ready low while busy", 32'(srch_ready), 0);
    search(2, 8'hC3, "R7 stalled search");
    @(negedge clk);
    cmd_valid = 1; cmd_op = 0; cmd_row = 2'd3; cmd_slot = 4'd1;
    cmd_value = '0; cmd_care = '0;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    m_val[2][0] = 1; m_v[2][0] = 8'hC3; m_c[2][0] = 8'hFF;
    @(negedge clk);
    check(err_busy === 1, "R9 err_busy set", 32'(err_busy), 1);
    search(3, 8'h00, "R9 ignored command left row3");
    search(2, 8'hC3, "R3 row2 rule");
    search(2, 8'hC2, "R3 row2 miss");
    check(err_busy === 1, "R9 err_busy sticky", 32'(err_busy), 1);

    // R10 out-of-range slot
    issue(1'b0, 0, CAP, 8'h00, 8'h00);
    check(busy === 0, "R10 no busy", 32'(busy), 0);
    @(negedge clk);
    check(done === 0, "R10 no done", 32'(done), 0);
    check(err_bound === 1, "R10 err_bound set", 32'(err_bound), 1);
    search(0, 8'h00, "R10 row0 unchanged");
    search(1, 8'h11, "R10 row1 unchanged");
    check(err_bound === 1, "R10 err_bound sticky", 32'(err_bound), 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results delivered", 32'(exp_q.size()), 0);
    finish_up();
  end
endmodule